// File: doc/BRIEF.md
# Segmented RAM Write Request Splitter

This block takes DMA write requests and turns each one into single-beat writes on a RAM port whose data word is divided into segments. A request gives a byte start address, a byte length and a payload of up to `MAX_LEN` bytes. Each segment of the port has its own valid bit and its own word address field. Byte enables and data are carried per byte lane across the whole word.

A beat carries only the bytes that fit between the current lane position and the end of the data word. A long or unaligned transfer is therefore cut into several beats that never cross a word boundary. The block keeps a count of bytes already sent for the request it holds. It resumes from that count on every beat and raises a one-cycle completion pulse once every byte has been accepted by the RAM. The block holds one request at a time. The upstream queue keeps its next request waiting until the request input is ready again.

Top module: `seg_ram_write_splitter`

## Requirements
- R1: `req_ready` is high only while no request is held. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until that request completes.
- R2: For each beat, the start lane is (start address + bytes sent) mod `DATA_BYTES`. The beat carries min(bytes left, `DATA_BYTES` − start lane) bytes, so a beat never crosses a data-word boundary.
- R3: Payload byte k (bits [8k+7:8k] of `req_data`) goes to byte lane (start address + k) mod `DATA_BYTES` of its beat, in `ram_data` bits [8l+7:8l], and `ram_be[l]` is set for that lane. Lanes not written in a beat carry zero data and a zero byte enable.
- R4: Segment s covers lanes s·`SEG_BYTES` to s·`SEG_BYTES`+`SEG_BYTES`−1. `ram_valid[s]` is high exactly when the beat writes at least one lane in that segment.
- R5: Field s of `ram_addr` (bits [12s+11:12s]) holds the low 12 bits of (start address + bytes sent) / `DATA_BYTES` for every valid segment. Fields of inactive segments are zero.
- R6: A beat is held unchanged while `ram_ready` is low. The block moves on only after a cycle with a valid segment and `ram_ready` high.
- R7: `done` is a single-cycle pulse in the cycle after the acknowledgement of the last beat. In that cycle `req_ready` is high and no segment is valid.
- R8: A zero-length request issues no beat. `done` pulses in the second cycle after acceptance.
- R9: After reset, `req_ready` is high, `done` is low and no segment is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Byte start address |
| req_len | input | LEN_W | Byte length, 0 to MAX_LEN |
| req_data | input | MAX_LEN*8 | Payload, byte k at bits [8k+7:8k] |
| ram_valid | output | SEG_CNT | Per-segment write valid |
| ram_ready | input | 1 | RAM accepts the current beat |
| ram_addr | output | SEG_CNT*SEG_ADDR_W | Per-segment word address |
| ram_be | output | DATA_BYTES | Byte enables |
| ram_data | output | DATA_BYTES*8 | Write data |
| done | output | 1 | Request completion pulse |

## Verification
The bench builds the block with its defaults: a 16-byte word in four 4-byte segments, a 32-bit address and a 64-byte payload. With these values a single request can span five beats. A transfer can start in the last lane of a word, or hit only one or two segments. With `ram_ready` held low, beats can be stalled, and an address above 16 bits exercises the 12-bit truncation of the word address.

// File: rtl/seg_ram_write_splitter.sv
module seg_ram_write_splitter #(
  parameter int ADDR_W     = 32,
  parameter int MAX_LEN    = 64,
  parameter int DATA_BYTES = 16,
  parameter int SEG_CNT    = 4,
  parameter int SEG_ADDR_W = 12,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int DATA_W    = DATA_BYTES * 8,
  localparam int PAY_W     = MAX_LEN * 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [LEN_W-1:0]              req_len,
  input  logic [PAY_W-1:0]              req_data,
  output logic [SEG_CNT-1:0]            ram_valid,
  input  logic                          ram_ready,
  output logic [SEG_CNT*SEG_ADDR_W-1:0] ram_addr,
  output logic [DATA_BYTES-1:0]         ram_be,
  output logic [DATA_W-1:0]             ram_data,
  output logic                          done
);

  localparam int SEG_BYTES = DATA_BYTES / SEG_CNT;
  localparam int LANE_W    = $clog2(DATA_BYTES);
  localparam int CNT_W     = (LEN_W > LANE_W + 1) ? LEN_W + 1 : LANE_W + 2;

  logic              busy;
  logic [ADDR_W-1:0] base;
  logic [LEN_W-1:0]  len_q, sent;
  logic [PAY_W-1:0]  pay;

  logic [ADDR_W-1:0]     pos;
  logic [LANE_W-1:0]     lane;
  logic [CNT_W-1:0]      room, rem, cnt;
  logic [DATA_BYTES:0]   fill;
  logic [DATA_W-1:0]     chunk, placed, lane_mask;
  logic [SEG_ADDR_W-1:0] word;
  logic                  active, ack, last;

  assign pos    = base + ADDR_W'(sent);
  assign lane   = pos[LANE_W-1:0];
  assign room   = CNT_W'(DATA_BYTES) - CNT_W'(lane);
  assign rem    = CNT_W'(len_q) - CNT_W'(sent);
  assign cnt    = (rem < room) ? rem : room;
  assign active = busy && (rem != '0);
  assign ack    = active && ram_ready;
  assign last   = ack && (cnt == rem);
  assign word   = SEG_ADDR_W'(pos >> LANE_W);

  assign fill   = ((DATA_BYTES + 1)'(1) << cnt) - (DATA_BYTES + 1)'(1);
  assign ram_be = active ? (fill[DATA_BYTES-1:0] << lane) : '0;

  assign chunk  = DATA_W'(pay >> {sent, 3'b000});
  assign placed = chunk << {lane, 3'b000};

  genvar b, s;
  generate
    for (b = 0; b < DATA_BYTES; b++) begin : g_lane
      assign lane_mask[b*8 +: 8] = {8{ram_be[b]}};
    end
    for (s = 0; s < SEG_CNT; s++) begin : g_seg
      assign ram_valid[s] = |ram_be[s*SEG_BYTES +: SEG_BYTES];
      assign ram_addr[s*SEG_ADDR_W +: SEG_ADDR_W] = ram_valid[s] ? word : '0;
    end
  endgenerate

  assign ram_data  = placed & lane_mask;
  assign req_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      base  <= '0;
      len_q <= '0;
      sent  <= '0;
      pay   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && req_valid) begin
        busy  <= 1'b1;
        base  <= req_addr;
        len_q <= req_len;
        pay   <= req_data;
        sent  <= '0;
      end else if (busy && rem == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (ack) begin
        sent <= sent + LEN_W'(cnt);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

module seg_ram_write_splitter_chk #(
  parameter int SEG_CNT    = 4,
  parameter int SEG_ADDR_W = 12,
  parameter int DATA_BYTES = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic [SEG_CNT-1:0]            ram_valid,
  input logic                          ram_ready,
  input logic [SEG_CNT*SEG_ADDR_W-1:0] ram_addr,
  input logic [DATA_BYTES-1:0]         ram_be,
  input logic [DATA_BYTES*8-1:0]       ram_data,
  input logic                          done
);

  a_r6_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ram_valid) && !ram_ready) |=>
      ($stable(ram_valid) && $stable(ram_be) && $stable(ram_data) && $stable(ram_addr)));

  a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_valid == '0 && ram_be == '0));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && ram_valid == '0));

endmodule

bind seg_ram_write_splitter seg_ram_write_splitter_chk #(
  .SEG_CNT(SEG_CNT), .SEG_ADDR_W(SEG_ADDR_W), .DATA_BYTES(DATA_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ram_valid(ram_valid), .ram_ready(ram_ready), .ram_addr(ram_addr),
  .ram_be(ram_be), .ram_data(ram_data), .done(done)
);

// File: tb/tb_seg_ram_write_splitter.sv
module tb_seg_ram_write_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32, MAX_LEN = 64, DATA_BYTES = 16, SEG_CNT = 4, SEG_ADDR_W = 12;
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int SEG_BYTES = DATA_BYTES / SEG_CNT;

  logic clk = 0, rst_n = 0, req_valid = 0, ram_ready = 0;
  logic req_ready, done;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [MAX_LEN*8-1:0] req_data = '0;
  logic [SEG_CNT-1:0] ram_valid;
  logic [SEG_CNT*SEG_ADDR_W-1:0] ram_addr;
  logic [DATA_BYTES-1:0] ram_be;
  logic [DATA_BYTES*8-1:0] ram_data;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_ram_write_splitter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
    .ram_valid(ram_valid), .ram_ready(ram_ready), .ram_addr(ram_addr),
    .ram_be(ram_be), .ram_data(ram_data), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int k, input logic [7:0] seed);
    return 8'(k * 29) + seed;
  endfunction

  task automatic expect_beat(input logic [31:0] a, input int len, input int sent, output int c);
    int lane, room;
    logic [DATA_BYTES-1:0] eb;
    logic [DATA_BYTES*8-1:0] ed;
    logic [SEG_CNT-1:0] ev;
    logic [SEG_CNT*SEG_ADDR_W-1:0] ea;
    logic [31:0] p;
    logic [7:0] seed;
    seed = req_data[7:0];
    p = a + 32'(sent);
    lane = int'(p % DATA_BYTES);
    room = DATA_BYTES - lane;
    c = (len - sent < room) ? len - sent : room;
    eb = '0; ed = '0; ev = '0; ea = '0;
    for (int i = 0; i < c; i++) begin
      ed[(lane+i)*8 +: 8] = pbyte(sent + i, seed);
      eb[lane+i] = 1'b1;
      ev[(lane+i)/SEG_BYTES] = 1'b1;
    end
    for (int s = 0; s < SEG_CNT; s++)
      if (ev[s]) ea[s*SEG_ADDR_W +: SEG_ADDR_W] = 12'(p / DATA_BYTES);
    chk("R2 byte enables", 256'(ram_be), 256'(eb));
    chk("R3 lane data", 256'(ram_data), 256'(ed));
    chk("R4 segment valid", 256'(ram_valid), 256'(ev));
    chk("R5 segment address", 256'(ram_addr), 256'(ea));
  endtask

  task automatic run_req(input logic [31:0] a, input int len, input bit stall, input logic [7:0] seed);
    int sent, c;
    chk("R1 ready before request", 256'(req_ready), 256'(1));
    req_addr = a;
    req_len = LEN_W'(len);
    // byte 0 doubles as the seed so expect_beat can recompute the pattern
    for (int k = 0; k < MAX_LEN; k++) req_data[k*8 +: 8] = pbyte(k, seed);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R1 ready low while held", 256'(req_ready), 256'(0));
    sent = 0;
    if (len == 0) begin
      chk("R8 no beat on zero length", 256'(ram_valid), 256'(0));
      chk("R8 done not yet", 256'(done), 256'(0));
      @(negedge clk);
    end
    while (sent < len) begin
      expect_beat(a, len, sent, c);
      if (stall) begin
        @(negedge clk);
        expect_beat(a, len, sent, c); // R6 beat held while ram_ready low
      end
      ram_ready = 1;
      @(negedge clk);
      ram_ready = 0;
      sent += c;
      if (sent < len) chk("R7 no early done", 256'(done), 256'(0));
    end
    chk("R7 done pulse", 256'(done), 256'(1));
    chk("R7 ready at done", 256'(req_ready), 256'(1));
    chk("R7 quiet at done", 256'(ram_valid), 256'(0));
    @(negedge clk);
    chk("R7 done single cycle", 256'(done), 256'(0));
  endtask

  task automatic t_reset;
    chk("R9 reset ready", 256'(req_ready), 256'(1));
    chk("R9 reset done", 256'(done), 256'(0));
    chk("R9 reset valid", 256'(ram_valid), 256'(0));
  endtask

  task automatic t_aligned;       run_req(32'h0000_0100, 16, 0, 8'h11); endtask
  task automatic t_short_inner;   run_req(32'h0000_0205, 3,  0, 8'h22); endtask
  task automatic t_cross_stall;   run_req(32'h0000_030D, 40, 1, 8'h33); endtask
  task automatic t_max_len;       run_req(32'h0000_040F, 64, 0, 8'h44); endtask
  task automatic t_last_lane;     run_req(32'h0000_050F, 1,  1, 8'h55); endtask
  task automatic t_zero_len;      run_req(32'h0000_0600, 0,  0, 8'h66); endtask
  task automatic t_addr_trunc;    run_req(32'h0012_3456, 20, 0, 8'h77); endtask

  task automatic t_ready_ignored_idle;
    // R6: ram_ready while idle must not produce a beat or a done
    ram_ready = 1;
    @(negedge clk);
    chk("R6 idle ready ignored valid", 256'(ram_valid), 256'(0));
    chk("R6 idle ready ignored done", 256'(done), 256'(0));
    ram_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_aligned;
    t_short_inner;
    t_cross_stall;
    t_max_len;
    t_last_lane;
    t_zero_len;
    t_addr_trunc;
    t_ready_ignored_idle;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule